// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Model

This block is a synthesizable model of a static memory with a read port and a write port that run independently, both on one input clock pair K/K#. Each access moves a pair of words. A read is requested with a low read strobe at a rising K edge, and the address on the bus at that edge names a word pair. A write is requested with a low write strobe at a rising K edge. The first data word and its byte enables are taken at that same edge. The write address, the second data word and its byte enables follow at the next rising K# edge, on the same shared address bus.

Read data leaves on a separate output bus. The first word of a burst is timed by the rising edge of C# and the second by the rising edge of C. When C and C# are both held high, K# and K time the outputs in their place. A valid flag marks the cycles in which a burst is on the bus, and the bus carries zeros at all other times. A pair of echo clocks runs without stopping, in step with the output word changes, so a receiver can capture the data with them.

Top module: `qdr_b2_sram`

## Requirements
- R1: A read strobe sampled low at a rising K edge t0 puts the word at internal index {addr,0} on rdata with rvalid high from the first output reference rising edge after t0 plus one cycle (C#, or K# at t0+1.5 cycles), and the word at {addr,1} from the next C (or K) rising edge. Back-to-back reads give an unbroken valid stream.
- R2: A write strobe sampled low at a rising K edge stores wdata of that edge at {A,0} and wdata of the following rising K# edge at {A,1}, where A is the address bus value at that K# edge.
- R3: Byte enables are active low and are sampled with each data word. Enable bit i covers wdata bits [BYTE_W*i +: BYTE_W] of that word only, and a high bit leaves that stored byte unchanged.
- R4: When the write strobe is high, no stored word changes, whatever the byte enables, data and address carry.
- R5: When both strobes are high, the address bus is ignored: the registered read address keeps its value and no later read returns anything other than the stored contents.
- R6: A read and a write in the same K cycle to the same pair return the newly written pair, merged with the old contents byte by byte under each word's own enables.
- R7: A write issued in the K cycle after a read to the same pair does not change the data that read returns.
- R8: Whenever rvalid is low, rdata is all zeros.
- R9: When C/C# toggle, they time the output words; when both are held high, K#/K time them, with the same latency in cycles.
- R10: cq rises with each second-word reference edge and cq_n with each first-word reference edge; the two stay complementary and keep toggling whether or not data is driven.
- R11: While reset is asserted, rvalid is low, rdata is zero, cq is high and cq_n is low.
- R12: rvalid is high only during the two output words of a read burst; a cycle without a read strobe gives no valid words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Input clock, rising edge samples strobes, read address and first write word |
| k_n | input | 1 | Complementary input clock, rising edge samples write address and second write word |
| c | input | 1 | Output reference clock for the second word (hold high with c_n to use K) |
| c_n | input | 1 | Output reference clock for the first word (hold high with c to use K#) |
| rst_n | input | 1 | Asynchronous active-low reset of all control state (storage is not cleared) |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Shared pair address: read address at K, write address at K# |
| wdata | input | BYTE_W*N_BYTES | Write data, one word per input clock edge |
| be_n | input | N_BYTES | Active-low byte enables, one set per write word |
| rdata | output | BYTE_W*N_BYTES | Read data, zero when not valid |
| rvalid | output | 1 | High while a read word is driven |
| cq | output | 1 | Echo clock aligned with second-word edges |
| cq_n | output | 1 | Echo clock aligned with first-word edges |

## Verification
The read snapshot and the write commit can fall in the same cycle: a read and a write naming the same pair in one K cycle must see the merged new data, while a write one cycle later must not. Both cases are provoked by directed steps with complementary byte masks and by random traffic confined to eight pairs so that collisions are frequent. A bench shadow memory applies each write before taking the expected data of the read issued in the same cycle, and the two output words are compared at the half cycles where they are expected, in both the K-referenced and the C-referenced output modes.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

   // Choice of output reference clocking
   typedef enum logic {
      REF_AUTO   = 1'b0,   // C/C# when toggling, K/K# when both held high
      REF_K_ONLY = 1'b1    // always K/K#, C/C# unused
   } out_ref_e;

   // Number of stored words for a given external pair address width
   function automatic int unsigned pair_words(input int unsigned aw);
      return 2 ** (aw + 1);
   endfunction

endpackage

// File: rtl/qdr_rd_cmd.sv
module qdr_rd_cmd #(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              k,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              rd_go,
   output logic [ADDR_W-1:0] rd_addr
);

   always_ff @(posedge k or negedge rst_n) begin
      if (!rst_n) begin
         rd_go   <= 1'b0;
         rd_addr <= '0;
      end else begin
         rd_go <= ~rd_n;
         if (!rd_n) rd_addr <= addr;
      end
   end

   // address bus must not disturb the read address register when no read is asked
   assert_addr_ignored_R5 : assert property (@(posedge k) disable iff (!rst_n)
      rd_n |=> $stable(rd_addr));

endmodule

// File: rtl/qdr_wr_cmd.sv
module qdr_wr_cmd #(
   parameter int unsigned BYTE_W  = 9,
   parameter int unsigned N_BYTES = 4,
   localparam int unsigned DATA_W = BYTE_W * N_BYTES
) (
   input  logic               k,
   input  logic               rst_n,
   input  logic               wr_n,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [N_BYTES-1:0] be_n,
   output logic               wr_pend,
   output logic [DATA_W-1:0]  w0_data,
   output logic [N_BYTES-1:0] w0_be_n
);

   // first half of a write: strobe, first word and its enables at rising K
   always_ff @(posedge k or negedge rst_n) begin
      if (!rst_n) begin
         wr_pend <= 1'b0;
         w0_data <= '0;
         w0_be_n <= '1;
      end else begin
         wr_pend <= ~wr_n;
         if (!wr_n) begin
            w0_data <= wdata;
            w0_be_n <= be_n;
         end
      end
   end

endmodule

// File: rtl/qdr_array.sv
module qdr_array #(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned BYTE_W  = 9,
   parameter int unsigned N_BYTES = 4,
   localparam int unsigned DATA_W = BYTE_W * N_BYTES,
   localparam int unsigned DEPTH  = qdr_pkg::pair_words(ADDR_W)
) (
   input  logic               k,
   input  logic               k_n,
   input  logic               rst_n,
   // write side, committed at rising K#
   input  logic               wr_pend,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  w0_data,
   input  logic [N_BYTES-1:0] w0_be_n,
   input  logic [DATA_W-1:0]  w1_data,
   input  logic [N_BYTES-1:0] w1_be_n,
   // read side, snapshot at rising K one cycle after the command
   input  logic               rd_go,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic               q_vld,
   output logic [DATA_W-1:0]  q0,
   output logic [DATA_W-1:0]  q1
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge k_n) begin
      if (wr_pend) begin
         for (int b = 0; b < N_BYTES; b++) begin
            if (!w0_be_n[b]) mem[{wr_addr, 1'b0}][b*BYTE_W +: BYTE_W] <= w0_data[b*BYTE_W +: BYTE_W];
            if (!w1_be_n[b]) mem[{wr_addr, 1'b1}][b*BYTE_W +: BYTE_W] <= w1_data[b*BYTE_W +: BYTE_W];
         end
      end
   end

   always_ff @(posedge k or negedge rst_n) begin
      if (!rst_n) q_vld <= 1'b0;
      else        q_vld <= rd_go;
   end

   always_ff @(posedge k) begin
      if (rd_go) begin
         q0 <= mem[{rd_addr, 1'b0}];
         q1 <= mem[{rd_addr, 1'b1}];
      end
   end

endmodule

// File: rtl/qdr_out_seq.sv
module qdr_out_seq #(
   parameter int unsigned DATA_W = 36
) (
   input  logic              oclk,
   input  logic              oclk_n,
   input  logic              rst_n,
   input  logic              q_vld,
   input  logic [DATA_W-1:0] q0,
   input  logic [DATA_W-1:0] q1,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              cq,
   output logic              cq_n
);

   logic              tog_a, tog_b, v0, v1, sel;
   logic [DATA_W-1:0] w0, w1, h1;

   // first-word edge: launch word 0, park word 1
   always_ff @(posedge oclk_n or negedge rst_n) begin
      if (!rst_n) begin
         tog_a <= 1'b0;
         v0    <= 1'b0;
         w0    <= '0;
         h1    <= '0;
      end else begin
         tog_a <= ~tog_a;
         v0    <= q_vld;
         w0    <= q_vld ? q0 : '0;
         h1    <= q_vld ? q1 : '0;
      end
   end

   // second-word edge: launch parked word 1
   always_ff @(posedge oclk or negedge rst_n) begin
      if (!rst_n) begin
         tog_b <= 1'b0;
         v1    <= 1'b0;
         w1    <= '0;
      end else begin
         tog_b <= tog_a;
         v1    <= v0;
         w1    <= h1;
      end
   end

   assign sel    = tog_a ^ tog_b;
   assign rdata  = sel ? w0 : w1;
   assign rvalid = sel ? v0 : v1;
   assign cq     = ~sel;
   assign cq_n   = sel;

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
   import qdr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned BYTE_W  = 9,
   parameter int unsigned N_BYTES = 4,
   parameter out_ref_e    OUT_REF = REF_AUTO,
   localparam int unsigned DATA_W = BYTE_W * N_BYTES
) (
   input  logic               k,
   input  logic               k_n,
   input  logic               c,
   input  logic               c_n,
   input  logic               rst_n,
   input  logic               rd_n,
   input  logic               wr_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [N_BYTES-1:0] be_n,
   output logic [DATA_W-1:0]  rdata,
   output logic               rvalid,
   output logic               cq,
   output logic               cq_n
);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("qdr_b2_sram: ADDR_W out of range");
   end
   if (BYTE_W < 1 || N_BYTES < 1) begin : g_bad_bytes
      $error("qdr_b2_sram: byte geometry must be non-zero");
   end

   logic               rd_go, wr_pend, q_vld, oclk, oclk_n;
   logic [ADDR_W-1:0]  rd_addr;
   logic [DATA_W-1:0]  w0_data, q0, q1;
   logic [N_BYTES-1:0] w0_be_n;

   // output reference selection
   if (OUT_REF == REF_K_ONLY) begin : g_kref
      assign oclk   = k;
      assign oclk_n = k_n;
   end else begin : g_autoref
      logic use_k;
      assign use_k  = c & c_n;
      assign oclk   = use_k ? k   : c;
      assign oclk_n = use_k ? k_n : c_n;
   end

   qdr_rd_cmd #(.ADDR_W(ADDR_W)) u_rd (
      .k(k), .rst_n(rst_n), .rd_n(rd_n), .addr(addr),
      .rd_go(rd_go), .rd_addr(rd_addr)
   );

   qdr_wr_cmd #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_wr (
      .k(k), .rst_n(rst_n), .wr_n(wr_n), .wdata(wdata), .be_n(be_n),
      .wr_pend(wr_pend), .w0_data(w0_data), .w0_be_n(w0_be_n)
   );

   qdr_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_mem (
      .k(k), .k_n(k_n), .rst_n(rst_n),
      .wr_pend(wr_pend), .wr_addr(addr),
      .w0_data(w0_data), .w0_be_n(w0_be_n),
      .w1_data(wdata), .w1_be_n(be_n),
      .rd_go(rd_go), .rd_addr(rd_addr),
      .q_vld(q_vld), .q0(q0), .q1(q1)
   );

   qdr_out_seq #(.DATA_W(DATA_W)) u_out (
      .oclk(oclk), .oclk_n(oclk_n), .rst_n(rst_n),
      .q_vld(q_vld), .q0(q0), .q1(q1),
      .rdata(rdata), .rvalid(rvalid), .cq(cq), .cq_n(cq_n)
   );

   // command history and arming used only by the checks below
   logic rd_h1, rd_h2, echo_armed;
   always_ff @(posedge k or negedge rst_n) begin
      if (!rst_n) begin
         rd_h1      <= 1'b0;
         rd_h2      <= 1'b0;
         echo_armed <= 1'b0;
      end else begin
         rd_h1      <= ~rd_n;
         rd_h2      <= rd_h1;
         echo_armed <= 1'b1;
      end
   end

   // word 0 of a read two K edges back is on the bus just before this edge (also R12)
   assert_read_valid_R1 : assert property (@(posedge k) disable iff (!rst_n)
      rvalid == rd_h2);

   assert_idle_zero_k_R8 : assert property (@(posedge k) disable iff (!rst_n)
      !rvalid |-> (rdata == '0));

   assert_idle_zero_kn_R8 : assert property (@(posedge k_n) disable iff (!rst_n)
      !rvalid |-> (rdata == '0));

   assert_echo_first_R10 : assert property (@(posedge k) disable iff (!rst_n)
      echo_armed |-> (!cq && cq_n));

   assert_echo_second_R10 : assert property (@(posedge k_n) disable iff (!rst_n)
      cq && !cq_n);

endmodule

// File: tb/tb_qdr_b2_sram.sv
module tb_qdr_b2_sram;

   localparam int AW = 6;
   localparam int BW = 9;
   localparam int NB = 4;
   localparam int DW = BW * NB;
   localparam int WORDS = 2 ** (AW + 1);

   logic          k, k_n, c, c_n, rst_n, rd_n, wr_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata;
   logic [NB-1:0] be_n;
   logic          rvalid, cq, cq_n;
   bit            cmode;

   int checks = 0;
   int errors = 0;
   int n = 0;

   logic [DW-1:0] shadow [WORDS];
   bit            ev [4];
   logic [DW-1:0] e0 [4];
   logic [DW-1:0] e1 [4];
   string         etag [4];

   qdr_b2_sram dut (
      .k(k), .k_n(k_n), .c(c), .c_n(c_n), .rst_n(rst_n),
      .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata), .be_n(be_n),
      .rdata(rdata), .rvalid(rvalid), .cq(cq), .cq_n(cq_n)
   );

   initial begin
      k = 1'b0;
      forever #5 k = ~k;
   end
   assign k_n = ~k;

   // output clocks: skewed copy of K when enabled, both held high otherwise
   initial begin c = 1'b1; c_n = 1'b1; end
   always @(k) begin
      #1;
      if (cmode) begin c = k; c_n = ~k; end
      else       begin c = 1'b1; c_n = 1'b1; end
   end

   task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [NB-1:0] m);
      logic [DW-1:0] r = old;
      for (int b = 0; b < NB; b++) if (!m[b]) r[b*BW +: BW] = nw[b*BW +: BW];
      return r;
   endfunction

   // one K cycle; entered 2.5 ns before the rising K edge
   task automatic step(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                       input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                       input logic [DW-1:0] d1, input logic [NB-1:0] m1, input string tag);
      int s;
      rd_n  = ~rd;
      wr_n  = ~wr;
      addr  = rd ? ra : AW'($urandom);
      wdata = d0;
      be_n  = m0;
      @(posedge k);
      #2.5;
      addr  = wr ? wa : AW'($urandom);
      wdata = d1;
      be_n  = m1;
      rd_n  = $urandom % 2;
      wr_n  = $urandom % 2;
      if (wr) begin
         shadow[{wa, 1'b0}] = merge(shadow[{wa, 1'b0}], d0, m0);
         shadow[{wa, 1'b1}] = merge(shadow[{wa, 1'b1}], d1, m1);
      end
      s = n % 4;
      ev[s]   = rd;
      e0[s]   = rd ? shadow[{ra, 1'b0}] : '0;
      e1[s]   = rd ? shadow[{ra, 1'b1}] : '0;
      etag[s] = tag;
      s = (n + 2) % 4;
      check(ev[s] ? {etag[s], " word1"} : "R8/R12 idle", {rvalid, rdata}, {ev[s], e1[s]});
      check("R10 echo second", {cq, cq_n, {(DW-1){1'b0}}}, {2'b10, {(DW-1){1'b0}}});
      #4.5;
      s = (n + 3) % 4;
      check(ev[s] ? {etag[s], " word0"} : "R8/R12 idle", {rvalid, rdata}, {ev[s], e0[s]});
      check("R10 echo first", {cq, cq_n, {(DW-1){1'b0}}}, {2'b01, {(DW-1){1'b0}}});
      #0.5;
      n++;
   endtask

   task automatic idle(input string tag);
      step(1'b0, '0, 1'b0, '0, DW'($urandom), NB'($urandom), DW'($urandom), '0, tag);
   endtask

   task automatic do_reset(input bit mode);
      rst_n = 1'b0;
      rd_n = 1'b1; wr_n = 1'b1; addr = '0; wdata = '0; be_n = '1;
      cmode = mode;
      repeat (3) @(posedge k);
      #3;
      check("R11 reset data", {rvalid, rdata}, '0);
      check("R11 reset echo", {cq, cq_n, {(DW-1){1'b0}}}, {2'b10, {(DW-1){1'b0}}});
      for (int i = 0; i < 4; i++) ev[i] = 1'b0;
      @(negedge k);
      rst_n = 1'b1;
      #2.5;
   endtask

   task automatic directed(input string mtag);
      logic [DW-1:0] d;
      // R1: back-to-back reads form one unbroken stream
      step(1, 6'd3, 0, 0, 0, '1, 0, '1, "R1");
      step(1, 6'd4, 0, 0, 0, '1, 0, '1, "R1");
      step(1, 6'd5, 0, 0, 0, '1, 0, '1, "R1");
      idle("R1");
      // R6: same-cycle read and write of one pair, complementary masks per word
      step(1, 6'd9, 1, 6'd9, DW'($urandom), 4'b0101, DW'($urandom), 4'b1010, "R6");
      // R7: write in the following cycle must not reach the earlier read
      step(1, 6'd10, 0, 0, 0, '1, 0, '1, "R7");
      step(0, 0, 1, 6'd10, DW'($urandom), 4'b0000, DW'($urandom), 4'b0000, "R7");
      step(1, 6'd10, 0, 0, 0, '1, 0, '1, "R7 after");
      // R4: strobe high, enables low: nothing stored
      d = DW'($urandom);
      step(0, 0, 0, 6'd11, d, 4'b0000, ~d, 4'b0000, "R4");
      step(1, 6'd11, 0, 0, 0, '1, 0, '1, "R4");
      // R3: single byte in word 0, all bytes masked in word 1
      step(0, 0, 1, 6'd12, DW'($urandom), 4'b1110, DW'($urandom), 4'b1111, "R3");
      step(1, 6'd12, 0, 0, 0, '1, 0, '1, "R3");
      // R5: idle cycles with garbage on the address bus, then read earlier address again
      step(1, 6'd13, 0, 0, 0, '1, 0, '1, "R5");
      repeat (3) idle("R5");
      step(1, 6'd13, 0, 0, 0, '1, 0, '1, "R5");
      idle(mtag);
   endtask

   task automatic random_run(input int cycles, input string tag);
      for (int i = 0; i < cycles; i++)
         step($urandom % 2, AW'($urandom % 8), $urandom % 2, AW'($urandom % 8),
              DW'({$urandom, $urandom}), NB'($urandom), DW'({$urandom, $urandom}), NB'($urandom), tag);
      idle(tag);
      idle(tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset(1'b0);
      // R2: fill every pair with full writes, then read a few back
      for (int a = 0; a < 2 ** AW; a++)
         step(0, 0, 1, AW'(a), DW'({$urandom, $urandom}), '0, DW'({$urandom, $urandom}), '0, "R2");
      for (int a = 0; a < 8; a++)
         step(1, AW'(a * 7), 0, 0, 0, '1, 0, '1, "R2");
      directed("R1");
      random_run(600, "R3");
      // R9: switch to C/C# referenced outputs
      do_reset(1'b1);
      directed("R9");
      random_run(600, "R9");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule